// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous memory in which every command moves through a fixed two-stage pipeline. Address and control are registered on a rising clock edge. The data belonging to that command then moves two enabled clock edges later, and this holds for a write as well as for a read. Because write data is delayed by the same amount as read data, reads and writes can be issued on consecutive cycles in any mix with no idle cycle between them.

A host starts an access by holding `adv` low with all three chip selects active. It can then continue a four-word burst by holding `adv` high. The low two address bits follow a linear or an interleaved order, and the mode is chosen when the burst is loaded. An active-low clock enable freezes the whole block. Per-lane write enables mask the bytes that a write changes. The shared data bus is split into `din`, `dout` and `dout_vld`, and the output is registered.

The burst sequencer is a two-state machine. In `BS_IDLE` no burst is open. In `BS_BURST` a burst is open and a continue cycle issues the next address. A selected load takes either state to `BS_BURST` (transition LOAD). A deselected load takes either state to `BS_IDLE` (transition DESELECT). A continue in `BS_BURST` stays there and steps the counter (transition ADVANCE). A continue in `BS_IDLE` stays there and issues nothing (transition PARK).

Top module: `pipe_sram`

## Requirements
- R1: Address, control, lane enables and burst mode are sampled only on the rising clock edge while `cke_n` is low.
- R2: A command sampled at enabled edge N has its data moved at enabled edge N+2. Write data is taken from `din` at that edge. Read data appears on `dout` just after that edge.
- R3: Reads and writes may be issued on every consecutive enabled cycle in any order with no idle cycle.
- R4: While `cke_n` is high, all inputs are ignored and all state holds, including `dout`, `dout_vld`, the pipeline and the burst position.
- R5: On a load cycle, `rd_wr_n` = 1 selects a read and `rd_wr_n` = 0 selects a write.
- R6: The device is selected only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. A load cycle (`adv`=0) while not selected starts nothing and closes any open burst.
- R7: A continue cycle (`adv`=1) with a burst open issues the next burst address, using the read/write type of the load. With no burst open, a continue cycle issues nothing.
- R8: Commands already in the pipeline complete their data transfer even when the device is deselected afterwards.
- R9: During a write, `lane_we_n[i]`=0 writes bits 8i+7..8i from `din`, and `lane_we_n[i]`=1 leaves that byte unchanged. The mask is sampled with each issued address.
- R10: `dout_vld` is high for exactly one enabled cycle per read, two enabled edges after it issued. Otherwise `dout_vld` is low and `dout` keeps its last read value.
- R11: With `burst_ilv`=0 at the load, the k-th access (k=0..3, repeating) uses low bits (base+k) mod 4, and the upper bits are unchanged.
- R12: With `burst_ilv`=1 at the load, the k-th access uses low bits base XOR k.
- R13: A read issued directly after a write to the same address returns the newly written data.
- R14: After reset, `dout`=0, `dout_vld`=0, all memory words are 0 and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Clock enable, low = run, high = freeze |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| adv | input | 1 | 0 = load new command, 1 = continue burst |
| rd_wr_n | input | 1 | 1 = read, 0 = write (load cycles) |
| lane_we_n | input | LANES | Per-byte write enables, active low |
| burst_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data, two cycles after its command |
| dout | output | LANES*LANE_W | Registered read data |
| dout_vld | output | 1 | High in the cycle `dout` carries fresh read data |

## Verification
The hardest situation to reach from the ports is a command that is already in flight when the block is stalled or deselected. In that case the data must still land at the right address on the right enabled edge. The bench keeps its own two-deep model of pending commands and pending write data, which advances only on enabled cycles. Every cycle it drives the data owed to the command issued two enabled cycles earlier. This lets the bench interleave stalls, deselects with each chip select in turn, and burst continues in the middle of traffic, and it compares `dout` and `dout_vld` on every cycle.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

    typedef enum logic {
        BS_IDLE  = 1'b0,
        BS_BURST = 1'b1
    } burst_state_e;

    // Low address bits of burst beat k from the starting low bits.
    function automatic logic [1:0] burst_lsb(input logic [1:0] base,
                                             input logic [1:0] k,
                                             input logic       ilv);
        return ilv ? (base ^ k) : (base + k);
    endfunction

endpackage

// File: rtl/psr_burst_ctl.sv
module psr_burst_ctl
    import pipe_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load_n,
    input  logic              sel,
    input  logic              rd_wr_n,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_wen_n,
    output logic              iss_vld,
    output logic              iss_wr,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [LANES-1:0]  iss_wen_n,
    output logic              burst_on
);

    burst_state_e      state, state_nx;
    logic [ADDR_W-1:0] base, base_nx;
    logic              bwr, bwr_nx;
    logic              bilv, bilv_nx;
    logic [1:0]        cnt, cnt_nx;
    logic [1:0]        cnt_inc;

    assign cnt_inc  = cnt + 2'd1;
    assign burst_on = (state == BS_BURST);

    // State register with the burst context it owns.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= BS_IDLE;
            base  <= '0;
            bwr   <= 1'b0;
            bilv  <= 1'b0;
            cnt   <= '0;
        end else if (en) begin
            state <= state_nx;
            base  <= base_nx;
            bwr   <= bwr_nx;
            bilv  <= bilv_nx;
            cnt   <= cnt_nx;
        end
    end

    // Transitions and issued command.
    always_comb begin
        state_nx  = state;
        base_nx   = base;
        bwr_nx    = bwr;
        bilv_nx   = bilv;
        cnt_nx    = cnt;
        iss_vld   = 1'b0;
        iss_wr    = bwr;
        iss_addr  = addr;
        iss_wen_n = lane_wen_n;
        if (!load_n) begin
            if (sel) begin                      // LOAD
                state_nx = BS_BURST;
                base_nx  = addr;
                bwr_nx   = !rd_wr_n;
                bilv_nx  = ilv;
                cnt_nx   = '0;
                iss_vld  = 1'b1;
                iss_wr   = !rd_wr_n;
            end else begin                      // DESELECT
                state_nx = BS_IDLE;
            end
        end else begin
            unique case (state)
                BS_IDLE: begin                  // PARK
                    state_nx = BS_IDLE;
                end
                BS_BURST: begin                 // ADVANCE
                    cnt_nx   = cnt_inc;
                    iss_vld  = 1'b1;
                    iss_wr   = bwr;
                    iss_addr = {base[ADDR_W-1:2], burst_lsb(base[1:0], cnt_inc, bilv)};
                end
                default: state_nx = BS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/psr_mem.sv
module psr_mem #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    op_vld,
    input  logic                    op_wr,
    input  logic [ADDR_W-1:0]       op_addr,
    input  logic [LANES-1:0]        op_wen_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvld
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rdata <= '0;
            rvld  <= 1'b0;
        end else if (en) begin
            rvld <= op_vld && !op_wr;
            if (op_vld && op_wr) begin
                for (int l = 0; l < LANES; l++)
                    if (!op_wen_n[l]) mem[op_addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
            end
            if (op_vld && !op_wr) rdata <= mem[op_addr];
        end
    end

endmodule

// File: rtl/pipe_sram.sv
module pipe_sram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke_n,
    input  logic                    cs0_n,
    input  logic                    cs1,
    input  logic                    cs2_n,
    input  logic                    adv,
    input  logic                    rd_wr_n,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic                    burst_ilv,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_vld
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int STAGES = 2;

    logic              en, sel, burst_on;
    logic              iss_vld, iss_wr;
    logic [ADDR_W-1:0] iss_addr;
    logic [LANES-1:0]  iss_wen_n;

    logic [STAGES-1:0] s_vld;
    logic [STAGES-1:0] s_wr;
    logic [ADDR_W-1:0] s_addr  [STAGES];
    logic [LANES-1:0]  s_wen_n [STAGES];

    assign en  = !cke_n;
    assign sel = !cs0_n && cs1 && !cs2_n;

    psr_burst_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .load_n    (adv),
        .sel       (sel),
        .rd_wr_n   (rd_wr_n),
        .ilv       (burst_ilv),
        .addr      (addr),
        .lane_wen_n(lane_we_n),
        .iss_vld   (iss_vld),
        .iss_wr    (iss_wr),
        .iss_addr  (iss_addr),
        .iss_wen_n (iss_wen_n),
        .burst_on  (burst_on)
    );

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic              in_vld, in_wr;
        logic [ADDR_W-1:0] in_addr;
        logic [LANES-1:0]  in_wen_n;
        if (g == 0) begin : g_head
            assign in_vld   = iss_vld;
            assign in_wr    = iss_wr;
            assign in_addr  = iss_addr;
            assign in_wen_n = iss_wen_n;
        end else begin : g_chain
            assign in_vld   = s_vld[g-1];
            assign in_wr    = s_wr[g-1];
            assign in_addr  = s_addr[g-1];
            assign in_wen_n = s_wen_n[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s_vld[g]   <= 1'b0;
                s_wr[g]    <= 1'b0;
                s_addr[g]  <= '0;
                s_wen_n[g] <= '1;
            end else if (en) begin
                s_vld[g]   <= in_vld;
                s_wr[g]    <= in_wr;
                s_addr[g]  <= in_addr;
                s_wen_n[g] <= in_wen_n;
            end
        end
    end

    psr_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .op_vld  (s_vld[STAGES-1]),
        .op_wr   (s_wr[STAGES-1]),
        .op_addr (s_addr[STAGES-1]),
        .op_wen_n(s_wen_n[STAGES-1]),
        .wdata   (din),
        .rdata   (dout),
        .rvld    (dout_vld)
    );

endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke_n,
    input logic              adv,
    input logic              sel,
    input logic              burst_on,
    input logic              s1_vld,
    input logic              s2_vld,
    input logic              s2_wr,
    input logic [DATA_W-1:0] dout,
    input logic              dout_vld
);

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(dout) && $stable(dout_vld) && $stable(s1_vld) && $stable(s2_vld))); // R4

    AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_n |=> (s2_vld == $past(s1_vld))); // R2

    AST_DESEL_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv && !sel) |=> (!s1_vld && !burst_on)); // R6

    AST_PARK_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv && !burst_on) |=> !s1_vld); // R7

    AST_VLD_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_n |=> (dout_vld == ($past(s2_vld) && !$past(s2_wr)))); // R10

endmodule

bind pipe_sram pipe_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cke_n   (cke_n),
    .adv     (adv),
    .sel     (sel),
    .burst_on(burst_on),
    .s1_vld  (s_vld[0]),
    .s2_vld  (s_vld[1]),
    .s2_wr   (s_wr[1]),
    .dout    (dout),
    .dout_vld(dout_vld)
);

// File: tb/pipe_sram_tb.sv
`timescale 1ns/1ps
module pipe_sram_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke_n = 1'b0;
    logic        cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1;
    logic        adv = 1'b0, rd_wr_n = 1'b1, burst_ilv = 1'b0;
    logic [3:0]  lane_we_n = 4'hF;
    logic [5:0]  addr = '0;
    logic [31:0] din = '0;
    logic [31:0] dout;
    logic        dout_vld;

    always #2.5 clk = ~clk;

    pipe_sram u_dut (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
        .adv(adv), .rd_wr_n(rd_wr_n), .lane_we_n(lane_we_n), .burst_ilv(burst_ilv),
        .addr(addr), .din(din), .dout(dout), .dout_vld(dout_vld)
    );

    int vectors = 0;
    int misses  = 0;
    string cur_req = "R14";

    // Reference state built from the requirements.
    logic [31:0] emem [64];
    logic        m_v [2];
    logic        m_w [2];
    logic [5:0]  m_a [2];
    logic [3:0]  m_m [2];
    logic [31:0] pend [2];
    logic        e_vld;
    logic [31:0] e_dout;
    logic        b_on, b_wr, b_ilv;
    logic [5:0]  b_base;
    logic [1:0]  b_k;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic ce_n, input logic c0n, input logic c1, input logic c2n,
                       input logic ad, input logic rw, input logic [3:0] wen,
                       input logic ilv, input logic [5:0] a, input logic [31:0] wd);
        logic [31:0] dd;
        logic sel;
        dd = pend[1];
        cke_n = ce_n; cs0_n = c0n; cs1 = c1; cs2_n = c2n; adv = ad; rd_wr_n = rw;
        lane_we_n = wen; burst_ilv = ilv; addr = a; din = dd;
        @(posedge clk);
        if (!ce_n) begin
            if (m_v[1] && m_w[1])
                for (int l = 0; l < 4; l++)
                    if (!m_m[1][l]) emem[m_a[1]][l*8 +: 8] = dd[l*8 +: 8];
            e_vld = m_v[1] && !m_w[1];
            if (e_vld) e_dout = emem[m_a[1]];
            m_v[1] = m_v[0]; m_w[1] = m_w[0]; m_a[1] = m_a[0]; m_m[1] = m_m[0];
            pend[1] = pend[0];
            pend[0] = wd;
            sel = !c0n && c1 && !c2n;
            m_v[0] = 1'b0;
            m_m[0] = wen;
            if (!ad) begin
                if (sel) begin
                    m_v[0] = 1'b1; m_w[0] = !rw; m_a[0] = a;
                    b_on = 1'b1; b_wr = !rw; b_ilv = ilv; b_base = a; b_k = 2'd0;
                end else b_on = 1'b0;
            end else if (b_on) begin
                b_k = b_k + 2'd1;
                m_v[0] = 1'b1; m_w[0] = b_wr;
                m_a[0] = {b_base[5:2], b_ilv ? (b_base[1:0] ^ b_k) : (b_base[1:0] + b_k)};
            end
        end
        @(negedge clk);
        chk({cur_req, " dout_vld"}, {31'd0, dout_vld}, {31'd0, e_vld});
        chk({cur_req, " dout"}, dout, e_dout);
    endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] m, input logic [31:0] d);
        cyc(0, 0, 1, 0, 0, 0, m, 0, a, d);
    endtask
    task automatic rd(input logic [5:0] a);
        cyc(0, 0, 1, 0, 0, 1, 4'hF, 0, a, 32'h0);
    endtask
    task automatic ld(input logic [5:0] a, input logic rw, input logic ilv, input logic [31:0] d);
        cyc(0, 0, 1, 0, 0, rw, 4'h0, ilv, a, d);
    endtask
    task automatic cont(input logic [31:0] d);
        cyc(0, 0, 1, 0, 1, 1, 4'h0, 0, 6'h3F, d);
    endtask
    task automatic idle();
        cyc(0, 1, 1, 0, 0, 1, 4'hF, 0, 6'h00, 32'h0);
    endtask
    task automatic stall();
        cyc(1, 0, 1, 0, 0, 0, 4'h0, 1, 6'h2A, 32'hDEADDEAD);
    endtask

    task automatic t_reset();
        cur_req = "R14";
        chk("R14 reset dout", dout, 32'h0);
        chk("R14 reset dout_vld", {31'd0, dout_vld}, 32'h0);
        rd(6'h3C); idle(); idle();
        chk("R14 reset memory zero", dout, 32'h0);
    endtask

    task automatic t_b2b();
        cur_req = "R3";
        wr(6'h05, 4'h0, 32'hA5A5_0001);
        cur_req = "R13";
        rd(6'h05);
        cur_req = "R3";
        wr(6'h06, 4'h0, 32'hB6B6_0002);
        rd(6'h06);
        cur_req = "R5";
        rd(6'h05);
        wr(6'h05, 4'h0, 32'hC5C5_0003);
        cur_req = "R13";
        rd(6'h05);
        cur_req = "R2";
        idle(); idle();
        chk("R2 final read data", dout, 32'hC5C5_0003);
    endtask

    task automatic t_stall();
        cur_req = "R4";
        wr(6'h07, 4'h0, 32'h7777_1234);
        stall(); stall(); stall();
        rd(6'h07);
        stall(); stall();
        idle();
        stall();
        idle(); idle();
        chk("R4 read across stalls", dout, 32'h7777_1234);
    endtask

    task automatic t_lanes();
        cur_req = "R9";
        wr(6'h08, 4'h0, 32'h1111_1111);
        wr(6'h08, 4'b1010, 32'hAABB_CCDD);
        rd(6'h08);
        idle(); idle();
        chk("R9 lane mask 1010", dout, 32'h11BB_11DD);
    endtask

    task automatic t_desel();
        cur_req = "R8";
        wr(6'h09, 4'h0, 32'h9999_0009);
        rd(6'h05);
        cur_req = "R6";
        cyc(0, 1, 1, 0, 0, 0, 4'h0, 0, 6'h09, 32'hBAD0_0001);
        cyc(0, 0, 0, 0, 0, 0, 4'h0, 0, 6'h09, 32'hBAD0_0002);
        cyc(0, 0, 1, 1, 0, 0, 4'h0, 0, 6'h09, 32'hBAD0_0003);
        idle();
        rd(6'h09);
        idle(); idle();
        chk("R6 deselected writes ignored", dout, 32'h9999_0009);
        ld(6'h10, 1, 0, 32'h0);
        cyc(0, 0, 0, 0, 0, 1, 4'hF, 0, 6'h00, 32'h0);
        cont(32'h0); cont(32'h0);
        idle();
        chk("R6 burst stopped by deselect", {31'd0, dout_vld}, 32'h0);
    endtask

    task automatic t_burst_lin();
        cur_req = "R11";
        wr(6'h10, 4'h0, 32'h0000_0010);
        wr(6'h11, 4'h0, 32'h0000_0011);
        wr(6'h12, 4'h0, 32'h0000_0012);
        wr(6'h13, 4'h0, 32'h0000_0013);
        ld(6'h12, 1, 0, 32'h0);
        cont(32'h0); cont(32'h0);
        chk("R11 beat0 addr 12", dout, 32'h0000_0012);
        cont(32'h0);
        chk("R11 beat1 addr 13", dout, 32'h0000_0013);
        idle();
        chk("R11 beat2 addr 10", dout, 32'h0000_0010);
        idle();
        chk("R11 beat3 addr 11", dout, 32'h0000_0011);
        cur_req = "R7";
        ld(6'h21, 0, 0, 32'hE000_0021);
        cont(32'hE000_0022); cont(32'hE000_0023); cont(32'hE000_0020);
        rd(6'h20); idle(); idle();
        chk("R7 burst write wrap to 20", dout, 32'hE000_0020);
    endtask

    task automatic t_burst_ilv();
        cur_req = "R12";
        ld(6'h11, 1, 1, 32'h0);
        cont(32'h0); cont(32'h0);
        chk("R12 beat0 addr 11", dout, 32'h0000_0011);
        cont(32'h0);
        chk("R12 beat1 addr 10", dout, 32'h0000_0010);
        idle();
        chk("R12 beat2 addr 13", dout, 32'h0000_0013);
        idle();
        chk("R12 beat3 addr 12", dout, 32'h0000_0012);
        ld(6'h13, 1, 1, 32'h0);
        cont(32'h0); cont(32'h0); cont(32'h0);
        idle(); idle();
    endtask

    task automatic t_park();
        cur_req = "R7";
        idle();
        cont(32'h0); cont(32'h0); cont(32'h0);
        chk("R7 continue without burst", {31'd0, dout_vld}, 32'h0);
        cur_req = "R10";
        rd(6'h06); idle();
        chk("R10 no valid before latency", {31'd0, dout_vld}, 32'h0);
        idle();
        chk("R10 valid at latency", {31'd0, dout_vld}, 32'h1);
        idle();
        chk("R10 valid one cycle", {31'd0, dout_vld}, 32'h0);
        chk("R10 dout held", dout, 32'hB6B6_0002);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) emem[i] = '0;
        for (int i = 0; i < 2; i++) begin
            m_v[i] = 1'b0; m_w[i] = 1'b0; m_a[i] = '0; m_m[i] = '1; pend[i] = '0;
        end
        e_vld = 1'b0; e_dout = '0;
        b_on = 1'b0; b_wr = 1'b0; b_ilv = 1'b0; b_base = '0; b_k = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        t_reset();
        t_b2b();
        t_stall();
        t_lanes();
        t_desel();
        t_burst_lin();
        t_burst_ilv();
        t_park();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        misses++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule